// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Receiver

This block takes a serial biphase-mark audio line, as carried by a consumer digital audio link, and recovers the audio words it carries. The timeslot period is known ahead of time and given as a runtime count of system clocks, so no clock recovery is done. A subframe begins where the line falls after the three high timeslots that open every preamble. The receiver then captures the remaining sixty timeslots, one sample per timeslot period and close to the middle of each slot.

Each completed subframe goes through three checks. Its eight-slot preamble must match the one expected at its place in the block. Its even parity must hold. Its validity flag must be clear. A subframe that passes all three is decoded pair by pair and justified to 16, 20 or 24 bits. It is then offered on a valid/ready output together with a left/right channel flag.

The output register holds one sample. While `out_valid` is high and `out_ready` is low, the sample and its channel flag stay unchanged. A sample that is decoded while the register is full and not being taken in that cycle is discarded, so the consumer must drain the register within one subframe time. A framing fault raises a sticky flag, and decoding carries on with the next subframe.

Top module: `spdrx_top`

## Requirements
- R1: After reset `out_valid`, `err_preamble` and `err_parity` are all 0.
- R2: A subframe is framed by a high-to-low change of `line_in` seen while idle. Timeslots 0..2 are taken as 1 and timeslot 3 as 0. Timeslots 4..63 are sampled near mid-slot, every `slot_div` clocks. `slot_div` must be at least 4 and must stay unchanged during a subframe.
- R3: Bit k (k = 4..31) is 1 when timeslots 2k and 2k+1 differ and 0 when they are equal. The audio word is bits 27..4, with bit 4 as its LSB.
- R4: Subframes are counted from 0 and the count wraps at BLOCK_LEN (default 384). The expected preamble, with slot 0 as its LSB, is 8'h17 for subframe 0, 8'h27 for odd subframes and 8'h47 for the other even subframes. A mismatch sets the sticky `err_preamble` and produces no sample.
- R5: Bits 4..31 must carry even parity. A failure sets the sticky `err_parity` and produces no sample.
- R6: A subframe whose bit 28 is 1 produces no sample and raises no error.
- R7: `width_sel` 0 gives the audio word shifted right by 8 (16 bits). 1 shifts it right by 4 (20 bits). 2 or 3 passes all 24 bits. `out_data` is zero above the chosen width.
- R8: `out_chan` is bit 0 of the subframe's index (0 = left on even subframes, 1 = right on odd ones).
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_chan` hold. After a transfer, `out_valid` falls unless a new sample loads in that cycle. A sample decoded while the register is full and not being taken is dropped.
- R10: The error flags stay set until reset. Subframes after a faulty one are still decoded and delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Biphase-mark serial line |
| slot_div | input | DIV_W | Timeslot period in system clocks |
| width_sel | input | 2 | Output width: 0 = 16, 1 = 20, 2/3 = 24 bits |
| out_valid | output | 1 | Sample register holds a sample |
| out_ready | input | 1 | Consumer accepts the sample this cycle |
| out_data | output | AUD_W | Right-justified audio sample |
| out_chan | output | 1 | Channel of the sample, 0 = left, 1 = right |
| err_preamble | output | 1 | Sticky: a preamble did not match its position |
| err_parity | output | 1 | Sticky: a subframe failed its parity check |

## Verification
The bench builds the receiver with BLOCK_LEN = 8 and DIV_W = 8. A block of 8 subframes brings the count wrap and the return to the subframe-0 preamble within reach many times over. The bench sweeps every timeslot divisor from 4 to 7 against every width setting, using fixed and computed audio patterns, which tests mid-slot sampling for both even and odd divisors. It then drives validity-flagged subframes, a held-off consumer with a second sample arriving, a parity fault, a preamble out of order and a reset in mid-stream. After each of these it checks the flags and the delivered samples at the ports.

// File: rtl/spdrx_pkg.sv
package spdrx_pkg;

  // Slot counts of one subframe
  localparam int SLOTS      = 64;
  localparam int LEAD_SLOTS = 4;
  localparam int CAP_SLOTS  = SLOTS - LEAD_SLOTS;

  // Leading slots implied by the framing edge: slots 2..0 high, slot 3 low
  localparam logic [LEAD_SLOTS-1:0] LEAD_PATTERN = 4'b0111;

  // Preamble slot patterns, slot 0 in bit 0
  localparam logic [7:0] PRE_BLOCK = 8'h17;
  localparam logic [7:0] PRE_ODD   = 8'h27;
  localparam logic [7:0] PRE_EVEN  = 8'h47;

  // Decoded bit positions
  localparam int AUD_LSB   = 4;
  localparam int AUD_MSB   = 27;
  localparam int VFLAG_BIT = 28;
  localparam int PAR_BIT   = 31;

  // Output width selection codes
  localparam logic [1:0] WSEL_16 = 2'd0;
  localparam logic [1:0] WSEL_20 = 2'd1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } slot_state_t;

endpackage

// File: rtl/spdrx_slot_sampler.sv
module spdrx_slot_sampler
  import spdrx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic [DIV_W-1:0]  slot_div,
  output logic              frame_done,
  output logic [SLOTS-1:0]  frame_slots
);

  localparam int CW = DIV_W + 1;
  localparam logic [5:0] LAST_IDX = 6'(CAP_SLOTS - 1);

  slot_state_t             state;
  logic                    line_d1, line_d2;
  logic [CW-1:0]           cnt;
  logic [5:0]              nsamp;
  logic [CAP_SLOTS-1:0]    cap_sr;
  logic                    fall;

  assign fall = line_d2 & ~line_d1;
  assign frame_slots = {cap_sr, LEAD_PATTERN};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d1 <= 1'b0;
      line_d2 <= 1'b0;
    end else begin
      line_d1 <= line_in;
      line_d2 <= line_d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      nsamp      <= '0;
      cap_sr     <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_RUN;
            nsamp <= '0;
            // first capture one and a half periods after the edge
            cnt   <= CW'(slot_div) + CW'(slot_div >> 1) - CW'(1);
          end
        end
        ST_RUN: begin
          if (cnt == '0) begin
            cap_sr <= {line_d1, cap_sr[CAP_SLOTS-1:1]};
            cnt    <= CW'(slot_div) - CW'(1);
            if (nsamp == LAST_IDX) begin
              state      <= ST_IDLE;
              frame_done <= 1'b1;
            end else begin
              nsamp <= nsamp + 6'd1;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (slot_div >= DIV_W'(4))); // R2

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state == ST_RUN)) |-> $stable(slot_div)); // R2

endmodule

// File: rtl/spdrx_decode.sv
module spdrx_decode
  import spdrx_pkg::*;
#(
  parameter int AUD_W = 24
) (
  input  logic [SLOTS-1:0] frame_slots,
  input  logic [7:0]       exp_pre,
  input  logic [1:0]       width_sel,
  output logic             pre_ok,
  output logic             par_ok,
  output logic             vflag,
  output logic [AUD_W-1:0] sample
);

  logic [PAR_BIT:AUD_LSB] bits;
  logic [AUD_W-1:0]       audio;

  for (genvar k = AUD_LSB; k <= PAR_BIT; k++) begin : g_pair
    assign bits[k] = frame_slots[2*k] ^ frame_slots[2*k+1];
  end

  assign audio  = bits[AUD_MSB:AUD_LSB];
  assign vflag  = bits[VFLAG_BIT];
  assign par_ok = ~(^bits);
  assign pre_ok = (frame_slots[7:0] == exp_pre);

  always_comb begin
    unique case (width_sel)
      WSEL_16: sample = audio >> (AUD_W - 16);
      WSEL_20: sample = audio >> (AUD_W - 20);
      default: sample = audio;
    endcase
  end

endmodule

// File: rtl/spdrx_outreg.sv
module spdrx_outreg #(
  parameter int AUD_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AUD_W-1:0] load_data,
  input  logic             load_chan,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [AUD_W-1:0] out_data,
  output logic             out_chan
);

  logic room;
  assign room = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= 1'b0;
    end else if (load && room) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_chan  <= load_chan;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan))); // R9

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid); // R9

endmodule

// File: rtl/spdrx_top.sv
module spdrx_top
  import spdrx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int AUD_W     = 24,
  parameter int BLOCK_LEN = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [DIV_W-1:0] slot_div,
  input  logic [1:0]       width_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AUD_W-1:0] out_data,
  output logic             out_chan,
  output logic             err_preamble,
  output logic             err_parity
);

  localparam int SF_W = $clog2(BLOCK_LEN);
  localparam logic [SF_W-1:0] SF_LAST = SF_W'(BLOCK_LEN - 1);

  logic             frame_done;
  logic [SLOTS-1:0] frame_slots;
  logic [SF_W-1:0]  sf_idx;
  logic [7:0]       exp_pre;
  logic             pre_ok, par_ok, vflag;
  logic [AUD_W-1:0] sample;
  logic             accept;

  spdrx_slot_sampler #(.DIV_W(DIV_W)) u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (line_in),
    .slot_div    (slot_div),
    .frame_done  (frame_done),
    .frame_slots (frame_slots)
  );

  always_comb begin
    if (sf_idx == '0)     exp_pre = PRE_BLOCK;
    else if (sf_idx[0])   exp_pre = PRE_ODD;
    else                  exp_pre = PRE_EVEN;
  end

  spdrx_decode #(.AUD_W(AUD_W)) u_decode (
    .frame_slots (frame_slots),
    .exp_pre     (exp_pre),
    .width_sel   (width_sel),
    .pre_ok      (pre_ok),
    .par_ok      (par_ok),
    .vflag       (vflag),
    .sample      (sample)
  );

  assign accept = frame_done & pre_ok & par_ok & ~vflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_idx       <= '0;
      err_preamble <= 1'b0;
      err_parity   <= 1'b0;
    end else if (frame_done) begin
      sf_idx       <= (sf_idx == SF_LAST) ? '0 : sf_idx + SF_W'(1);
      err_preamble <= err_preamble | ~pre_ok;
      err_parity   <= err_parity | ~par_ok;
    end
  end

  spdrx_outreg #(.AUD_W(AUD_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (sample),
    .load_chan (sf_idx[0]),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan)
  );

  AST_SF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_idx <= SF_LAST); // R4

  AST_LOAD_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_done && pre_ok && par_ok && !vflag)); // R5

  AST_PRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_preamble |=> err_preamble); // R10

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity); // R10

endmodule

// File: tb/tb_spdrx_top.sv
`timescale 1ns/1ps
module tb_spdrx_top;

  localparam int DIV_W = 8;
  localparam int AUD_W = 24;
  localparam int BLK   = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_in = 1'b0;
  logic [DIV_W-1:0] slot_div = 8'd4;
  logic [1:0]       width_sel = 2'd2;
  logic             out_ready = 1'b1;
  logic             out_valid;
  logic [AUD_W-1:0] out_data;
  logic             out_chan;
  logic             err_preamble, err_parity;

  int checks = 0;
  int fails = 0;
  int exp_n = 0;
  int got_n = 0;
  int sf = 0;
  bit finished = 0;
  logic [AUD_W:0] exp_q [0:511];

  always #4 clk = ~clk;

  spdrx_top #(.DIV_W(DIV_W), .AUD_W(AUD_W), .BLOCK_LEN(BLK)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .slot_div(slot_div),
    .width_sel(width_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan),
    .err_preamble(err_preamble), .err_parity(err_parity)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Delivered samples: R3, R7 and R8 are checked here against the model
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      chk((got_n < exp_n) && ({out_chan, out_data} == exp_q[got_n]),
          "R3/R7/R8 delivered sample", {7'd0, out_chan, out_data}, {7'd0, exp_q[got_n]});
      got_n++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input logic rdy);
    @(posedge clk);
    #2 out_ready = rdy;
  endtask

  // Build and drive one subframe; keep=1 records the expected sample
  task automatic send_sf(input logic [23:0] aud, input bit vb, input bit badpar,
                         input bit badpre, input bit keep);
    logic [63:0] s;
    logic [31:0] b;
    logic [7:0]  pre, want;
    logic        lvl;
    int          sh;
    want = (sf == 0) ? 8'h17 : (sf % 2 == 1) ? 8'h27 : 8'h47;
    pre  = badpre ? ((want == 8'h47) ? 8'h27 : 8'h47) : want;
    b = '0;
    b[27:4] = aud;
    b[28]   = vb;
    b[31]   = (^b[30:4]) ^ badpar;
    s = '0;
    s[7:0] = pre;
    lvl = s[7];
    for (int i = 4; i < 32; i++) begin
      s[2*i]   = ~lvl;
      s[2*i+1] = ~lvl ^ b[i];
      lvl      = s[2*i+1];
    end
    sh = (width_sel == 2'd0) ? 8 : (width_sel == 2'd1) ? 4 : 0;
    if (keep && !vb && !badpar && !badpre) begin
      exp_q[exp_n] = {1'(sf % 2), aud >> sh};
      exp_n++;
    end
    for (int k = 0; k < 64; k++) begin
      line_in = s[k];
      repeat (int'(slot_div)) @(negedge clk);
    end
    repeat (3 * int'(slot_div)) @(negedge clk);
    sf = (sf + 1) % BLK;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [23:0] aud;
    rst_n = 1'b0;
    idle(5);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 0);
    chk(err_preamble == 1'b0 && err_parity == 1'b0, "R1 flags after reset",
        {30'd0, err_preamble, err_parity}, 0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    idle(10);

    // R2 R3 R7: divisor by width by pattern sweep
    for (int d = 4; d <= 7; d++) begin
      for (int w = 0; w <= 2; w++) begin
        slot_div  = DIV_W'(d);
        width_sel = 2'(w);
        for (int p = 0; p < 8; p++) begin
          case (p)
            0: aud = 24'hFFFFFF;
            1: aud = 24'h000000;
            2: aud = 24'hAAAAAA;
            3: aud = 24'h555555;
            4: aud = 24'h800000;
            5: aud = 24'h000001;
            default: aud = 24'(32'h9E3779B9 * (p * 13 + d * 3 + w + 1));
          endcase
          send_sf(aud, 0, 0, 0, 1);
        end
      end
    end
    idle(10);
    chk(got_n == exp_n, "R2 sample count after sweep", got_n, exp_n);
    chk(err_preamble == 1'b0, "R4 block order across wraps", {31'd0, err_preamble}, 0);
    chk(err_parity == 1'b0, "R5 no parity fault on good stream", {31'd0, err_parity}, 0);

    // R6: validity flag set
    slot_div  = 8'd4;
    width_sel = 2'd3;
    send_sf(24'h123456, 1, 0, 0, 1);
    send_sf(24'hFEDCBA, 1, 0, 0, 1);
    send_sf(24'h0F0F0F, 1, 0, 0, 1);
    chk(got_n == exp_n, "R6 flagged subframes give no sample", got_n, exp_n);
    chk(err_preamble == 1'b0 && err_parity == 1'b0, "R6 flagged subframes raise no error",
        {30'd0, err_preamble, err_parity}, 0);
    send_sf(24'hC0FFEE, 0, 0, 0, 1);   // R7 code 3 passes 24 bits

    // R9: back-pressure, second sample dropped
    set_ctl(1'b0);
    send_sf(24'h13579B, 0, 0, 0, 1);
    send_sf(24'h2468AC, 0, 0, 0, 0);
    idle(4);
    chk(out_valid == 1'b1, "R9 sample held while not ready", {31'd0, out_valid}, 1);
    chk({out_chan, out_data} == exp_q[got_n], "R9 held sample is the first",
        {7'd0, out_chan, out_data}, {7'd0, exp_q[got_n]});
    set_ctl(1'b1);
    idle(3);
    chk(out_valid == 1'b0, "R9 second sample dropped", {31'd0, out_valid}, 0);
    chk(got_n == exp_n, "R9 delivered count", got_n, exp_n);

    // R5 then R10: parity fault, decoding continues
    send_sf(24'h777777, 0, 1, 0, 1);
    chk(err_parity == 1'b1, "R5 parity fault flagged", {31'd0, err_parity}, 1);
    chk(err_preamble == 1'b0, "R5 parity fault leaves preamble flag", {31'd0, err_preamble}, 0);
    chk(got_n == exp_n, "R5 no sample from bad parity", got_n, exp_n);
    width_sel = 2'd0;
    send_sf(24'hABCDEF, 0, 0, 0, 1);
    send_sf(24'h314159, 0, 0, 0, 1);
    chk(got_n == exp_n, "R10 decoding resumes after parity fault", got_n, exp_n);
    chk(err_parity == 1'b1, "R10 parity flag sticky", {31'd0, err_parity}, 1);

    // R4: preamble out of order
    send_sf(24'h111111, 0, 0, 1, 1);
    chk(err_preamble == 1'b1, "R4 preamble mismatch flagged", {31'd0, err_preamble}, 1);
    chk(got_n == exp_n, "R4 no sample from bad preamble", got_n, exp_n);
    width_sel = 2'd1;
    send_sf(24'h272727, 0, 0, 0, 1);
    send_sf(24'h828282, 0, 0, 0, 1);
    chk(got_n == exp_n, "R10 decoding resumes after preamble fault", got_n, exp_n);
    chk(err_preamble == 1'b1, "R10 preamble flag sticky", {31'd0, err_preamble}, 1);

    // R1 R10: reset clears flags, counting restarts at subframe 0
    @(posedge clk);
    #2 rst_n = 1'b0;
    idle(3);
    chk(out_valid == 1'b0 && err_preamble == 1'b0 && err_parity == 1'b0,
        "R10 flags cleared only by reset", {29'd0, out_valid, err_preamble, err_parity}, 0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    line_in = 1'b0;
    idle(10);
    sf = 0;
    width_sel = 2'd2;
    send_sf(24'h5EED00, 0, 0, 0, 1);
    send_sf(24'h00D1CE, 0, 0, 0, 1);
    chk(got_n == exp_n, "R8 final sample count", got_n, exp_n);
    chk(err_preamble == 1'b0, "R4 block restarts after reset", {31'd0, err_preamble}, 0);
    summary();
  end

endmodule